// File: doc/BRIEF.md
# Synchronizing Edge Detector

This block takes a single-bit control input that changes with no fixed relation to the destination clock. It presents that input as a clean level in the destination domain, and it raises a one-cycle strobe for each rising transition and each falling transition. The input is only ever sampled as data on the destination clock. It never drives a flip-flop clock pin.

In the default mode the input passes through a synchronizer chain of `SYNC_STAGES` flops (two by default). The last flop of the chain is the synchronized level. A small tracking state machine keeps one more registered copy of that level, and the strobes come from comparing the level with that copy. The first and possibly metastable flop therefore never reaches the edge logic.

Setting `SAME_DOMAIN` to 1 is for an input that already belongs to the destination clock. In this mode the synchronizer chain is removed, the level output follows the input directly, and the tracker's single register is the only stage. The tracker has two states:
- `TRK_LOW`: the last registered level was 0. The transition to `TRK_HIGH` happens on a rising edge.
- `TRK_HIGH`: the last registered level was 1. The transition to `TRK_LOW` happens on a falling edge.

Top module: `sync_edge_detect`

## Requirements
- R1: In default mode, `level_out` equals the value of `async_in` captured two destination clock edges earlier.
- R2: `rise_pulse` is 1 when the current level is 1 and the tracker's registered copy is 0. In default mode it goes high in the same cycle that `level_out` goes from 0 to 1.
- R3: `fall_pulse` is 1 when the current level is 0 and the tracker's registered copy is 1. In default mode it goes high in the same cycle that `level_out` goes from 1 to 0.
- R4: Each strobe lasts exactly one destination cycle for each input transition, and the two strobes are never high together.
- R5: While `rst_n` is low in default mode, every stage is cleared and all three outputs are 0. After reset is released with the input low, no strobe fires.
- R6: With `SAME_DOMAIN` = 1, `level_out` follows `async_in` with no delay. `rise_pulse` is `async_in` & ~(its value at the previous edge), and `fall_pulse` is the mirror of that.
- R7: In default mode, a high pulse on `async_in` that lasts two destination cycles produces exactly one rising strobe and then one falling strobe.
- R8: For any sequence of input toggles that each hold for at least three destination cycles, the count of strobes equals the count of toggles. Each strobe has the polarity of its toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Destination clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| async_in | input | 1 | Raw control input |
| level_out | output | 1 | Synchronized level |
| rise_pulse | output | 1 | One-cycle strobe on a 0-to-1 transition |
| fall_pulse | output | 1 | One-cycle strobe on a 1-to-0 transition |

## Verification
The hardest situation to reach is the shortest input pulse the block still accepts. That pulse is two destination cycles wide, so its rising and falling strobes arrive only two cycles apart while the chain still holds both values. A directed sequence drives exactly such a two-cycle high pulse and then a two-cycle low gap. It then runs a random stream of toggles held for three to seven cycles. One input feeds both modes side by side, so the latency of each mode is compared against the same history.

// File: rtl/sed_pkg.sv
`timescale 1ns/1ps
package sed_pkg;
    // Tracker state: registered copy of the level seen by edge logic
    typedef enum logic {
        TRK_LOW  = 1'b0,
        TRK_HIGH = 1'b1
    } trk_state_e;
endpackage

// File: rtl/sed_sync_chain.sv
`timescale 1ns/1ps
module sed_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    for (genvar i = 0; i < STAGES; i++) begin : g_stg
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= 1'b0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= 1'b0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sed_edge_track.sv
`timescale 1ns/1ps
module sed_edge_track
    import sed_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    trk_state_e st_q, st_d;

    // Next state: the tracker follows the level one cycle behind
    always_comb begin
        st_d = lvl ? TRK_HIGH : TRK_LOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TRK_LOW;
        else        st_q <= st_d;
    end

    // Outputs: a level that differs from the stored state is an edge
    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (st_q)
            TRK_LOW:  rise = lvl;
            TRK_HIGH: fall = ~lvl;
        endcase
    end
endmodule

// File: rtl/sync_edge_detect.sv
`timescale 1ns/1ps
module sync_edge_detect #(
    parameter bit          SAME_DOMAIN = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_out,
    output logic rise_pulse,
    output logic fall_pulse
);
    logic lvl;

    if (SAME_DOMAIN) begin : g_bypass
        assign lvl = async_in;
    end else begin : g_sync
        sed_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (async_in),
            .q     (lvl)
        );
    end

    sed_edge_track u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .rise  (rise_pulse),
        .fall  (fall_pulse)
    );

    assign level_out = lvl;
endmodule

// File: rtl/sed_checker.sv
`timescale 1ns/1ps
module sed_checker #(
    parameter bit          SAME_DOMAIN = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic async_in,
    input logic level_out,
    input logic rise_pulse,
    input logic fall_pulse
);
    logic [1:0] cyc;  // edges since reset release, saturating at 3

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && rise_pulse) |-> (level_out && !$past(level_out)));

    p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && fall_pulse) |-> (!level_out && $past(level_out)));

    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_pulse && fall_pulse));

    p_rise_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

    p_fall_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse);

    if (!SAME_DOMAIN) begin : g_sync_chk
        p_reset_clear_r5: assert property (@(posedge clk)
            !rst_n |-> (!level_out && !rise_pulse && !fall_pulse));

        if (SYNC_STAGES == 2) begin : g_two
            p_level_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (cyc >= 2'd2) |-> (level_out == $past(async_in, 2)));
        end
    end
endmodule

bind sync_edge_detect sed_checker #(
    .SAME_DOMAIN (SAME_DOMAIN),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (async_in),
    .level_out  (level_out),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse)
);

// File: tb/sim_sync_edge_detect.sv
`timescale 1ns/1ps
module sim_sync_edge_detect;
    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic din = 1'b0;
    logic lvl0, rise0, fall0, lvl1, rise1, fall1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic h[4];  // h[k] = value driven k cycles ago
    int toggles = 0, rises = 0, falls = 0, exp_r = 0, exp_f = 0;

    always #10 clk = ~clk;  // 50 MHz

    sync_edge_detect u0 (.clk(clk), .rst_n(rst_n), .async_in(din),
        .level_out(lvl0), .rise_pulse(rise0), .fall_pulse(fall0));

    sync_edge_detect #(.SAME_DOMAIN(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .async_in(din),
        .level_out(lvl1), .rise_pulse(rise1), .fall_pulse(fall1));

    function automatic logic exp_rise(logic cur, logic prv);
        return cur & ~prv;
    endfunction

    function automatic logic exp_fall(logic cur, logic prv);
        return ~cur & prv;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cnt_chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One destination cycle: drive after the edge, sample before the next
    task automatic step(logic nv);
        @(posedge clk);
        #5;
        if (nv != h[0]) toggles++;
        din = nv;
        h[3] = h[2]; h[2] = h[1]; h[1] = h[0]; h[0] = nv;
        #10;
        chk("R1 level", lvl0, h[2]);
        chk("R2 rise", rise0, exp_rise(h[2], h[3]));
        chk("R3 fall", fall0, exp_fall(h[2], h[3]));
        chk("R4 exclusive", rise0 & fall0, 1'b0);
        chk("R6 bypass level", lvl1, h[0]);
        chk("R6 bypass rise", rise1, exp_rise(h[0], h[1]));
        chk("R6 bypass fall", fall1, exp_fall(h[0], h[1]));
        if (rise0) rises++;
        if (fall0) falls++;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        for (int k = 0; k < 4; k++) h[k] = 1'b0;
        #1 rst_n = 1'b0;
        // R5: outputs held at zero in reset even with input high
        repeat (2) @(posedge clk);
        #5 din = 1'b1;
        repeat (3) @(posedge clk);
        #15;
        chk("R5 reset level", lvl0, 1'b0);
        chk("R5 reset rise", rise0, 1'b0);
        chk("R5 reset fall", fall0, 1'b0);
        @(posedge clk);
        #5 din = 1'b0;
        @(posedge clk);
        #5 rst_n = 1'b1;
        // R5: input low after release gives no strobe
        for (int k = 0; k < 4; k++) step(1'b0);
        cnt_chk("R5 no strobe after reset", rises + falls, 0);

        // R7: two-cycle high pulse, then two-cycle low gap, then a second pulse
        rises = 0; falls = 0;
        step(1'b1); step(1'b1); step(1'b0); step(1'b0);
        step(1'b1); step(1'b1);
        for (int k = 0; k < 5; k++) step(1'b0);
        cnt_chk("R7 rise count", rises, 2);
        cnt_chk("R7 fall count", falls, 2);

        // R8: random toggles with hold of three to seven cycles
        rises = 0; falls = 0; toggles = 0; exp_r = 0; exp_f = 0;
        for (int n = 0; n < 400; n++) begin
            logic nv;
            int hold;
            nv = ~h[0];
            if (nv) exp_r++; else exp_f++;
            hold = 3 + int'($urandom % 5);
            for (int k = 0; k < hold; k++) step(nv);
        end
        for (int k = 0; k < 4; k++) step(h[0]);
        cnt_chk("R8 strobes vs toggles", rises + falls, toggles);
        cnt_chk("R8 rising strobes", rises, exp_r);
        cnt_chk("R8 falling strobes", falls, exp_f);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule